// File: doc/BRIEF.md
# Page-Mapped Display Scan-Out Engine

This block turns a page-organized monochrome frame memory into a raster pixel stream for a 96-column by 16-row window. In the frame memory each byte holds eight vertically stacked pixels. A page is a band of eight lines, and each page takes 132 bytes of the memory. On a frame request the engine walks the window from top to bottom and left to right. For each pixel it issues one read to a synchronous memory port with one cycle of latency, takes the right bit from the returned byte, and emits one pixel per cycle with valid, line-start and frame-start markers.

Four controls shape the image. The first is a vertical start line that scrolls the window through the 64 memory lines with wrap-around. The second is an inverse control that flips the polarity of the pixels. The third is an entire-display-on control that lights every pixel. The fourth is a display enable that darkens every pixel. All four are sampled when a request is accepted and stay fixed for that frame. The visible columns begin at a fixed offset of 36 inside each page.

Top module: `pageScanOut`

## Requirements
- R1: A frame request sampled high at a clock edge while `busy` is low starts a frame. After that edge, `busy` and `memRdEn` are high. The first pixel is valid one cycle later, and exactly 1536 valid pixels follow on consecutive cycles.
- R2: Pixels come row by row, top to bottom, and left to right within a row. `lineStart` is high on the first pixel of each row. `frameStart` is high only on the first pixel of the frame.
- R3: For visible row y and column x, the memory line is (y + startLine) mod 64. The read address is (line / 8) * 132 + 36 + x, and the pixel uses bit (line mod 8) of the returned byte, where bit 0 is the least significant.
- R4: With inverse, entire-on and disable all inactive, a set memory bit gives `pixOut` = 1 and a clear bit gives 0.
- R5: With `inverseEn` high, a set memory bit gives `pixOut` = 0 and a clear bit gives 1.
- R6: With `allOnEn` high and the display enabled, every pixel is 1 whatever the memory holds, and inverse has no effect.
- R7: With `displayEn` low, every pixel is 0. This holds even when `allOnEn` or `inverseEn` is high.
- R8: A frame request is ignored while `busy` is high, and the frame in progress goes on unchanged. A request held high across the end of a frame starts the next frame at the first edge where `busy` is low.
- R9: `startLine`, `inverseEn`, `allOnEn` and `displayEn` are sampled at the edge that accepts the request. Changing them during a frame does not change any pixel of that frame.
- R10: `memRdEn` is high exactly one cycle before each valid pixel. While `pixValid` is low, `pixOut`, `lineStart` and `frameStart` are 0.
- R11: `busy` is high from the cycle after the accepting edge up to and including the cycle that issues the last read. It is low while the last pixel is shown.
- R12: While reset is held and just after it, `pixValid`, `pixOut`, `lineStart`, `frameStart`, `memRdEn` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameReq | input | 1 | Frame request, sampled at each rising edge |
| startLine | input | 6 | Vertical scroll: memory line shown on row 0 |
| inverseEn | input | 1 | Invert pixel polarity |
| allOnEn | input | 1 | Light every pixel |
| displayEn | input | 1 | Display enable; low darkens every pixel |
| memRdEn | output | 1 | Frame memory read strobe |
| memAddr | output | 11 | Frame memory byte address |
| memRdData | input | 8 | Read data, valid one cycle after the strobe |
| pixOut | output | 1 | Pixel value, 1 = lit |
| pixValid | output | 1 | Pixel valid |
| lineStart | output | 1 | First pixel of a row |
| frameStart | output | 1 | First pixel of a frame |
| busy | output | 1 | Frame reads in progress |

## Verification
After the edge that accepts a request, `busy`, `memRdEn` and the address of pixel 0 are due in the same cycle. Pixel k, with its markers, is due k+1 cycles after that. The last pixel is due one cycle after `busy` falls. The bench model stores one expected entry per cycle in a queue when it sees the accepting edge. It compares the head of the queue with the outputs at the falling edge, and it compares the read strobe and address against the next entry. Requests made while the queue is not empty leave the queue untouched. Because of this, ignored requests, requests held across a frame boundary and mid-frame control changes are checked against the same per-cycle schedule.

// File: rtl/scanOutPkg.sv
package scanOutPkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_t;

  // Strobes sent from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic issue;      // a read for (rowIdx, colIdx) goes out this cycle
    logic capture;    // sample the frame controls at this edge
    logic rowFirst;   // this read belongs to column 0 of a row
    logic frameFirst; // this read belongs to row 0, column 0
  } scanStrobe_t;

endpackage

// File: rtl/scanOutCtrl.sv
module scanOutCtrl
  import scanOutPkg::*;
#(
  parameter  int VIS_COLS = 96,
  parameter  int VIS_ROWS = 16,
  localparam int COL_W    = $clog2(VIS_COLS),
  localparam int ROW_W    = $clog2(VIS_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameReq,
  output scanStrobe_t       strobe,
  output logic [COL_W-1:0]  colIdx,
  output logic [ROW_W-1:0]  rowIdx,
  output logic              busy
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(VIS_COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(VIS_ROWS - 1);

  scanState_t state;
  logic       colWrap;
  logic       frameDone;

  assign colWrap   = (colIdx == LAST_COL);
  assign frameDone = colWrap && (rowIdx == LAST_ROW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      colIdx <= '0;
      rowIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frameReq) begin
            state  <= ST_SCAN;
            colIdx <= '0;
            rowIdx <= '0;
          end
        end
        ST_SCAN: begin
          if (colWrap) begin
            colIdx <= '0;
            if (frameDone) begin
              state  <= ST_IDLE;
              rowIdx <= '0;
            end else begin
              rowIdx <= rowIdx + 1'b1;
            end
          end else begin
            colIdx <= colIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.issue      = (state == ST_SCAN);
    strobe.capture    = (state == ST_IDLE) && frameReq;
    strobe.rowFirst   = (state == ST_SCAN) && (colIdx == '0);
    strobe.frameFirst = (state == ST_SCAN) && (colIdx == '0) && (rowIdx == '0);
  end

  assign busy = (state == ST_SCAN);

endmodule

// File: rtl/scanOutPath.sv
module scanOutPath
  import scanOutPkg::*;
#(
  parameter  int VIS_COLS   = 96,
  parameter  int VIS_ROWS   = 16,
  parameter  int MEM_COLS   = 132,
  parameter  int COL_OFFSET = 36,
  parameter  int LINES      = 64,
  parameter  int BYTE_W     = 8,
  localparam int COL_W      = $clog2(VIS_COLS),
  localparam int ROW_W      = $clog2(VIS_ROWS),
  localparam int LINE_W     = $clog2(LINES),
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int PAGES      = LINES / BYTE_W,
  localparam int PAGE_W     = LINE_W - BIT_W,
  localparam int ADDR_W     = $clog2(MEM_COLS * PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobe,
  input  logic [COL_W-1:0]  colIdx,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [LINE_W-1:0] startLine,
  input  logic              inverseEn,
  input  logic              allOnEn,
  input  logic              displayEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              pixOut,
  output logic              pixValid,
  output logic              lineStart,
  output logic              frameStart
);

  // Frame controls held for the whole frame.
  logic [LINE_W-1:0] startQ;
  logic              invQ;
  logic              allOnQ;
  logic              enQ;

  // Line translation: scroll, then split the line into page and bit.
  logic [LINE_W-1:0] memLine;
  logic [PAGE_W-1:0] pageIdx;
  logic [BIT_W-1:0]  bitIdx;

  // One stage that lines up with the memory latency.
  logic              validQ;
  logic              rowFirstQ;
  logic              frameFirstQ;
  logic [BIT_W-1:0]  bitQ;
  logic              rawBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      invQ   <= 1'b0;
      allOnQ <= 1'b0;
      enQ    <= 1'b0;
    end else if (strobe.capture) begin
      startQ <= startLine;
      invQ   <= inverseEn;
      allOnQ <= allOnEn;
      enQ    <= displayEn;
    end
  end

  // The sum wraps at LINES because LINES is a power of two.
  assign memLine = LINE_W'(rowIdx) + startQ;
  assign pageIdx = memLine[LINE_W-1:BIT_W];
  assign bitIdx  = memLine[BIT_W-1:0];

  assign memRdEn = strobe.issue;
  assign memAddr = ADDR_W'(pageIdx) * ADDR_W'(MEM_COLS)
                 + ADDR_W'(COL_OFFSET)
                 + ADDR_W'(colIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ      <= 1'b0;
      rowFirstQ   <= 1'b0;
      frameFirstQ <= 1'b0;
      bitQ        <= '0;
    end else begin
      validQ      <= strobe.issue;
      rowFirstQ   <= strobe.rowFirst;
      frameFirstQ <= strobe.frameFirst;
      bitQ        <= bitIdx;
    end
  end

  assign rawBit = memRdData[bitQ];

  // Disable overrides entire-on, and entire-on overrides inverse.
  always_comb begin
    if (!validQ || !enQ) pixOut = 1'b0;
    else if (allOnQ)     pixOut = 1'b1;
    else                 pixOut = rawBit ^ invQ;
  end

  assign pixValid   = validQ;
  assign lineStart  = rowFirstQ;
  assign frameStart = frameFirstQ;

endmodule

// File: rtl/pageScanOut.sv
module pageScanOut
  import scanOutPkg::*;
#(
  parameter  int VIS_COLS   = 96,
  parameter  int VIS_ROWS   = 16,
  parameter  int MEM_COLS   = 132,
  parameter  int COL_OFFSET = 36,
  parameter  int LINES      = 64,
  parameter  int BYTE_W     = 8,
  localparam int LINE_W     = $clog2(LINES),
  localparam int PAGES      = LINES / BYTE_W,
  localparam int ADDR_W     = $clog2(MEM_COLS * PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameReq,
  input  logic [LINE_W-1:0] startLine,
  input  logic              inverseEn,
  input  logic              allOnEn,
  input  logic              displayEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              pixOut,
  output logic              pixValid,
  output logic              lineStart,
  output logic              frameStart,
  output logic              busy
);

  localparam int COL_W = $clog2(VIS_COLS);
  localparam int ROW_W = $clog2(VIS_ROWS);

  scanStrobe_t      strobe;
  logic [COL_W-1:0] colIdx;
  logic [ROW_W-1:0] rowIdx;

  scanOutCtrl #(
    .VIS_COLS (VIS_COLS),
    .VIS_ROWS (VIS_ROWS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameReq (frameReq),
    .strobe   (strobe),
    .colIdx   (colIdx),
    .rowIdx   (rowIdx),
    .busy     (busy)
  );

  scanOutPath #(
    .VIS_COLS   (VIS_COLS),
    .VIS_ROWS   (VIS_ROWS),
    .MEM_COLS   (MEM_COLS),
    .COL_OFFSET (COL_OFFSET),
    .LINES      (LINES),
    .BYTE_W     (BYTE_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .colIdx     (colIdx),
    .rowIdx     (rowIdx),
    .startLine  (startLine),
    .inverseEn  (inverseEn),
    .allOnEn    (allOnEn),
    .displayEn  (displayEn),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .pixOut     (pixOut),
    .pixValid   (pixValid),
    .lineStart  (lineStart),
    .frameStart (frameStart)
  );

endmodule

// File: rtl/pageScanOutChecker.sv
module pageScanOutChecker #(
  parameter  int VIS_COLS   = 96,
  parameter  int VIS_ROWS   = 16,
  parameter  int MEM_COLS   = 132,
  parameter  int COL_OFFSET = 36,
  parameter  int LINES      = 64,
  parameter  int BYTE_W     = 8,
  localparam int PAGES      = LINES / BYTE_W,
  localparam int ADDR_W     = $clog2(MEM_COLS * PAGES),
  localparam int TOTAL      = VIS_COLS * VIS_ROWS,
  localparam int CNT_W      = $clog2(TOTAL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameReq,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixOut,
  input logic              pixValid,
  input logic              lineStart,
  input logic              frameStart,
  input logic              busy
);

  // Counts the valid pixels since the last frame start.
  logic [CNT_W-1:0] pixCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         pixCnt <= '0;
    else if (pixValid) pixCnt <= frameStart ? CNT_W'(1) : pixCnt + 1'b1;
  end

  // R1: an accepted request starts reads in the next cycle
  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && !busy) |=> (busy && memRdEn));

  // R1: no frame runs past its pixel count
  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !frameStart) |-> (pixCnt != '0 && int'(pixCnt) < TOTAL));

  // R8: a new frame starts only once the previous one is complete
  p_frame_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (pixCnt == '0 || int'(pixCnt) == TOTAL));

  // R2: the frame marker always falls on a row start
  p_frame_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> lineStart);

  // R3: every read lands inside the visible column window of a page
  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ((int'(memAddr) % MEM_COLS) >= COL_OFFSET
             && (int'(memAddr) % MEM_COLS) < COL_OFFSET + VIS_COLS
             && int'(memAddr) < MEM_COLS * PAGES));

  // R10: each read is followed by a valid pixel
  p_read_leads_r10: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> pixValid);

  // R10: no valid pixel without a read in the cycle before
  p_no_read_no_pix_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memRdEn |=> !pixValid);

  // R10: outputs stay quiet outside valid pixels
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (!pixOut && !lineStart && !frameStart));

endmodule

bind pageScanOut pageScanOutChecker #(
  .VIS_COLS   (VIS_COLS),
  .VIS_ROWS   (VIS_ROWS),
  .MEM_COLS   (MEM_COLS),
  .COL_OFFSET (COL_OFFSET),
  .LINES      (LINES),
  .BYTE_W     (BYTE_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .frameReq   (frameReq),
  .memRdEn    (memRdEn),
  .memAddr    (memAddr),
  .pixOut     (pixOut),
  .pixValid   (pixValid),
  .lineStart  (lineStart),
  .frameStart (frameStart),
  .busy       (busy)
);

// File: tb/pageScanOut_bench.sv
module pageScanOut_bench;

  localparam int CLK_PERIOD = 10;
  localparam int COLS       = 96;
  localparam int ROWS       = 16;
  localparam int MEM_COLS   = 132;
  localparam int COL_OFFSET = 36;
  localparam int LINES      = 64;
  localparam int MEM_BYTES  = MEM_COLS * (LINES / 8);

  typedef struct {
    bit v;
    bit p;
    bit ls;
    bit fs;
    bit bz;
    int addr;
  } entry_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameReq = 1'b0;
  logic [5:0]  startLine = '0;
  logic        inverseEn = 1'b0;
  logic        allOnEn = 1'b0;
  logic        displayEn = 1'b1;
  logic        memRdEn;
  logic [10:0] memAddr;
  logic [7:0]  memRdData = '0;
  logic        pixOut;
  logic        pixValid;
  logic        lineStart;
  logic        frameStart;
  logic        busy;

  logic [7:0]  benchMem [MEM_BYTES];
  entry_t      expQ [$];
  string       frameTag = "R4";
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pageScanOut u_pageScanOut (
    .clk        (clk),
    .rstN       (rstN),
    .frameReq   (frameReq),
    .startLine  (startLine),
    .inverseEn  (inverseEn),
    .allOnEn    (allOnEn),
    .displayEn  (displayEn),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .pixOut     (pixOut),
    .pixValid   (pixValid),
    .lineStart  (lineStart),
    .frameStart (frameStart),
    .busy       (busy)
  );

  // Frame memory with one cycle of read latency.
  always @(posedge clk) begin
    if (memRdEn) memRdData <= benchMem[memAddr];
  end

  // Reference model: when a request is accepted, queue one entry per
  // cycle after that edge. An empty queue means the engine is free.
  always @(posedge clk) begin
    entry_t e;
    int ln;
    int a;
    bit b;
    if (!rstN) begin
      expQ.delete();
    end else if (frameReq && expQ.size() == 0) begin
      e.v = 0; e.p = 0; e.ls = 0; e.fs = 0; e.bz = 1; e.addr = 0;
      expQ.push_back(e);
      for (int y = 0; y < ROWS; y++) begin
        for (int x = 0; x < COLS; x++) begin
          ln = (y + int'(startLine)) % LINES;
          a  = (ln / 8) * MEM_COLS + COL_OFFSET + x;
          b  = benchMem[a][ln % 8];
          e.v  = 1;
          e.p  = !displayEn ? 1'b0 : (allOnEn ? 1'b1 : (b ^ inverseEn));
          e.ls = (x == 0);
          e.fs = (x == 0) && (y == 0);
          e.bz = !((y == ROWS - 1) && (x == COLS - 1));
          e.addr = a;
          expQ.push_back(e);
        end
      end
    end
  end

  // Compare once per cycle, at the falling edge.
  always @(negedge clk) begin
    entry_t e;
    bit expRd;
    int expAddr;
    bit bad;
    if (rstN && !done) begin
      if (expQ.size() > 0) e = expQ[0];
      else begin
        e.v = 0; e.p = 0; e.ls = 0; e.fs = 0; e.bz = 0; e.addr = 0;
      end
      expRd   = (expQ.size() > 1) && expQ[1].v;
      expAddr = (expQ.size() > 1) ? expQ[1].addr : 0;
      tests++;
      bad = 0;
      if (pixValid !== e.v) begin
        $display("FAIL R1 pixValid=%0b expected %0b", pixValid, e.v); bad = 1;
      end
      if (lineStart !== e.ls || frameStart !== e.fs) begin
        $display("FAIL R2 lineStart/frameStart=%0b%0b expected %0b%0b",
                 lineStart, frameStart, e.ls, e.fs); bad = 1;
      end
      if (e.v && pixOut !== e.p) begin
        $display("FAIL %s pixOut=%0b expected %0b", frameTag, pixOut, e.p); bad = 1;
      end
      if (!e.v && pixOut !== 1'b0) begin
        $display("FAIL R10 pixOut=%0b expected 0 outside valid", pixOut); bad = 1;
      end
      if (busy !== e.bz) begin
        $display("FAIL R11 busy=%0b expected %0b", busy, e.bz); bad = 1;
      end
      if (memRdEn !== expRd) begin
        $display("FAIL R10 memRdEn=%0b expected %0b", memRdEn, expRd); bad = 1;
      end
      if (expRd && int'(memAddr) != expAddr) begin
        $display("FAIL R3 memAddr=%0d expected %0d", memAddr, expAddr); bad = 1;
      end
      if (bad) fails++;
      if (expQ.size() > 0) void'(expQ.pop_front());
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() != 0 || busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic runFrame(input logic [5:0] sl, input bit inv, input bit on,
                          input bit en, input string tag);
    @(negedge clk);
    frameTag  = tag;
    startLine = sl;
    inverseEn = inv;
    allOnEn   = on;
    displayEn = en;
    frameReq  = 1'b1;
    @(negedge clk);
    frameReq  = 1'b0;
    waitIdle();
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < MEM_BYTES; i++)
      benchMem[i] = 8'((i * 73 + seed) ^ (i >> 2));
  endtask

  initial begin
    fillMem(29);
    repeat (3) @(negedge clk);
    // R12: reset state
    tests++;
    if (pixValid !== 0 || pixOut !== 0 || lineStart !== 0 || frameStart !== 0
        || memRdEn !== 0 || busy !== 0) begin
      fails++;
      $display("FAIL R12 outputs v%0b p%0b l%0b f%0b r%0b b%0b expected all 0",
               pixValid, pixOut, lineStart, frameStart, memRdEn, busy);
    end
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if (pixValid !== 0 || memRdEn !== 0 || busy !== 0) begin
      fails++;
      $display("FAIL R12 after reset v%0b r%0b b%0b expected 000",
               pixValid, memRdEn, busy);
    end

    runFrame(6'd0,  1'b0, 1'b0, 1'b1, "R4");   // normal polarity
    runFrame(6'd5,  1'b0, 1'b0, 1'b1, "R3");   // scroll inside pages
    runFrame(6'd60, 1'b0, 1'b0, 1'b1, "R3");   // scroll wraps past line 63
    runFrame(6'd17, 1'b1, 1'b0, 1'b1, "R5");   // inverse
    runFrame(6'd9,  1'b1, 1'b1, 1'b1, "R6");   // entire-on beats inverse
    runFrame(6'd3,  1'b1, 1'b1, 1'b0, "R7");   // disabled beats everything
    fillMem(101);
    runFrame(6'd33, 1'b0, 1'b0, 1'b1, "R4");

    // R8: requests during a frame are ignored
    @(negedge clk);
    frameTag = "R8"; startLine = 6'd12; inverseEn = 0; allOnEn = 0; displayEn = 1;
    frameReq = 1'b1;
    @(negedge clk);
    frameReq = 1'b0;
    repeat (400) @(negedge clk);
    startLine = 6'd40;
    frameReq = 1'b1;
    repeat (8) @(negedge clk);
    frameReq = 1'b0;
    waitIdle();

    // R8: request held across the frame end starts the next frame
    @(negedge clk);
    frameTag = "R8"; startLine = 6'd50;
    frameReq = 1'b1;
    repeat (COLS * ROWS + 6) @(negedge clk);
    frameReq = 1'b0;
    waitIdle();

    // R9: control changes during a frame have no effect
    @(negedge clk);
    frameTag = "R9"; startLine = 6'd21; inverseEn = 0; allOnEn = 0; displayEn = 1;
    frameReq = 1'b1;
    @(negedge clk);
    frameReq = 1'b0;
    repeat (300) @(negedge clk);
    startLine = 6'd2; inverseEn = 1;
    repeat (300) @(negedge clk);
    allOnEn = 1;
    repeat (300) @(negedge clk);
    displayEn = 0;
    waitIdle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1'b1;
    tests++;
    fails++;
    $display("FAIL watchdog expired, run incomplete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule